// File: doc/BRIEF.md
# Transactional Line Buffer Controller

This block is a small fully associative line buffer that sits next to a core's primary data cache and holds every line the core touches while a hardware transaction is open. Each entry carries a two-bit state: empty, normal (plain data outside any transaction), saved (the copy that was valid before the transaction started) or speculative (a copy written inside the open transaction). The first transactional write to a normal line keeps both copies in two entries: the old one becomes saved and the written one becomes speculative.

Closing the outermost transaction turns every speculative entry into a normal one and frees every saved entry in one clock. An abort does the reverse in one clock: speculative entries are freed and saved entries become normal again. An abort has three sources. A snoop from another core that matches a speculative line, a transactional write that finds no free entry, or an external abort request. Speculative data never leaves the block through the snoop port. Transactions do not nest. A begin inside an open transaction only deepens a counter, and only the matching outermost end commits.

The local load/store port is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle and stays unchanged until `rsp_ready` accepts it. `req_ready` is low while a response is waiting, so the port holds one request at a time. Snoops cannot be stalled: each snoop gets a response exactly one cycle later. Writes always carry a whole line.

Top module: `txbuf_ctrl`

## Requirements
- R1: After a synchronous reset every entry is empty, no transaction is open, and `rsp_valid`, `abort_o` and `snp_rsp_valid` are low while `req_ready` is high.
- R2: Outside a transaction, a write that hits a normal line overwrites it. A write that misses takes the lowest empty entry as a normal line. A later read returns the written line with `rsp_hit`=1. A write that finds no empty entry answers `rsp_hit`=0 and raises no abort.
- R3: The response appears one cycle after the request is accepted. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_hit` and `rsp_data` hold their values.
- R4: Inside a transaction, the first write to a normal line keeps the old copy as saved and puts the new data in a second, speculative entry. A write that misses allocates a speculative entry. Local reads return the speculative copy.
- R5: When the outermost end is seen, speculative lines become normal and saved lines become empty in one cycle. After that, reads return the committed data and the freed entries can be allocated again.
- R6: On any abort, speculative lines become empty and saved lines become normal in one cycle. Reads then return the pre-transaction data, or miss for lines first created in the transaction. The transaction is closed.
- R7: A snoop whose address matches a speculative line answers with `snp_rsp_conflict`=1, `snp_rsp_hit`=0 and zero data. In the same cycle it pulses `abort_o` with `abort_cause`=1. A snoop that matches only a normal or saved line answers with `snp_rsp_hit`=1 and that line's data, and raises no abort.
- R8: A transactional write that needs a new entry when none is empty answers `rsp_hit`=0 and aborts with `abort_cause`=2.
- R9: A begin while a transaction is open increases the nesting depth. An end only decreases it until the depth returns to zero, and only that end commits. An end while idle has no effect.
- R10: `tx_abort` while a transaction is open aborts it with `abort_cause`=3. While idle it has no effect.
- R11: A read that matches no valid line answers `rsp_hit`=0 with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request valid |
| req_ready | output | 1 | Local request can be accepted |
| req_write | input | 1 | 1 = whole-line write, 0 = read |
| req_addr | input | ADDR_W | Line address of the local request |
| req_wdata | input | LINE_W | Write line |
| rsp_valid | output | 1 | Local response valid |
| rsp_ready | input | 1 | Local response accepted |
| rsp_hit | output | 1 | Read hit, or write accepted |
| rsp_data | output | LINE_W | Read line (zero for writes and misses) |
| snp_valid | input | 1 | Snoop request from another core |
| snp_addr | input | ADDR_W | Snoop line address |
| snp_rsp_valid | output | 1 | Snoop response, one cycle after the request |
| snp_rsp_hit | output | 1 | Non-speculative line supplied |
| snp_rsp_conflict | output | 1 | Snoop matched speculative data |
| snp_rsp_data | output | LINE_W | Supplied line or zero |
| tx_begin | input | 1 | Start (or nest) a transaction |
| tx_end | input | 1 | End a transaction level |
| tx_abort | input | 1 | External abort request |
| tx_active | output | 1 | A transaction is open |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_cause | output | 2 | 1 snoop, 2 overflow, 3 external |

## Verification
The bench builds the block with four entries, 32-bit lines, 8-bit line addresses and a 3-bit nesting counter. With only four entries the buffer can be filled completely by a few writes. That makes overflow reachable, and it lets the bench prove at the port that saved entries were freed by commit or restored by abort: it counts how many further allocations succeed. Narrow lines keep the data values easy to read, and nesting two levels deep covers the case where an inner end must not commit.

// File: rtl/txbuf_pkg.sv
`timescale 1ns/1ps
package txbuf_pkg;

  typedef enum logic [1:0] {
    TAG_EMPTY   = 2'd0,
    TAG_NORMAL  = 2'd1,
    TAG_XCOMMIT = 2'd2,
    TAG_XABORT  = 2'd3
  } tag_e;

  typedef enum logic [1:0] {
    ABT_NONE     = 2'd0,
    ABT_SNOOP    = 2'd1,
    ABT_OVERFLOW = 2'd2,
    ABT_EXTERNAL = 2'd3
  } abort_e;

  // state after a successful outermost end
  function automatic logic [1:0] tag_on_commit(input logic [1:0] t);
    if (t == TAG_XABORT)  return TAG_NORMAL;
    if (t == TAG_XCOMMIT) return TAG_EMPTY;
    return t;
  endfunction

  // state after a transaction is discarded
  function automatic logic [1:0] tag_on_abort(input logic [1:0] t);
    if (t == TAG_XABORT)  return TAG_EMPTY;
    if (t == TAG_XCOMMIT) return TAG_NORMAL;
    return t;
  endfunction

endpackage

// File: rtl/txbuf_match.sv
`timescale 1ns/1ps
module txbuf_match
  import txbuf_pkg::*;
#(
  parameter int N  = 64,
  parameter int AW = 27
)(
  input  logic [N-1:0][1:0]    tags,
  input  logic [N-1:0][AW-1:0] addrs,
  input  logic [AW-1:0]        key,
  output logic [N-1:0]         spec_hit,
  output logic [N-1:0]         clean_hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic same;
    assign same         = (addrs[g] == key);
    assign spec_hit[g]  = same && (tags[g] == TAG_XABORT);
    assign clean_hit[g] = same && ((tags[g] == TAG_NORMAL) || (tags[g] == TAG_XCOMMIT));
  end
endmodule

// File: rtl/txbuf_pick.sv
`timescale 1ns/1ps
module txbuf_pick #(
  parameter int N  = 64,
  parameter int IW = 6
)(
  input  logic [N-1:0]  free_vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/txbuf_rdmux.sv
`timescale 1ns/1ps
module txbuf_rdmux #(
  parameter int N = 64,
  parameter int W = 256
)(
  input  logic [N-1:0] sel,
  input  logic [W-1:0] lines [N],
  output logic [W-1:0] q
);
  always_comb begin
    q = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) q = q | lines[i];
    end
  end
endmodule

// File: rtl/txbuf_nest.sv
`timescale 1ns/1ps
module txbuf_nest #(
  parameter int DW = 4
)(
  input  logic clk,
  input  logic rst,
  input  logic begin_i,
  input  logic end_i,
  input  logic abort_i,
  output logic active_o,
  output logic commit_o
);
  localparam logic [DW-1:0] MAXD = {DW{1'b1}};
  localparam logic [DW-1:0] ONE  = DW'(1);

  logic [DW-1:0] depth_q;

  assign active_o = (depth_q != '0);
  assign commit_o = end_i && !begin_i && !abort_i && (depth_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q <= '0;
    end else if (abort_i) begin
      depth_q <= '0;
    end else if (begin_i && !end_i && depth_q != MAXD) begin
      depth_q <= depth_q + ONE;
    end else if (end_i && !begin_i && depth_q != '0) begin
      depth_q <= depth_q - ONE;
    end
  end
endmodule

// File: rtl/txbuf_ctrl.sv
`timescale 1ns/1ps
module txbuf_ctrl
  import txbuf_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int LINE_W  = 256,
  parameter int ADDR_W  = 27,
  parameter int NEST_W  = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LINE_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [LINE_W-1:0] rsp_data,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_rsp_valid,
  output logic              snp_rsp_hit,
  output logic              snp_rsp_conflict,
  output logic [LINE_W-1:0] snp_rsp_data,
  input  logic              tx_begin,
  input  logic              tx_end,
  input  logic              tx_abort,
  output logic              tx_active,
  output logic              abort_o,
  output logic [1:0]        abort_cause
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // entry storage
  logic [ENTRIES-1:0][1:0]        tag_q, tag_w, tag_d;
  logic [ENTRIES-1:0][ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0]              data_q [ENTRIES];

  // lookups
  logic [ENTRIES-1:0] spec_l, clean_l, spec_s, clean_s, free_vec, rd_sel, wr_vec;
  logic               found;
  logic [IDX_W-1:0]   fidx;
  logic [LINE_W-1:0]  rd_line, snp_line;

  logic accept, ovf, wr_ok, snp_conflict, ext_abort, abort_now, commit_now;
  abort_e cause;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  txbuf_match #(.N(ENTRIES), .AW(ADDR_W)) u_match_loc (
    .tags(tag_q), .addrs(addr_q), .key(req_addr),
    .spec_hit(spec_l), .clean_hit(clean_l)
  );

  txbuf_match #(.N(ENTRIES), .AW(ADDR_W)) u_match_snp (
    .tags(tag_q), .addrs(addr_q), .key(snp_addr),
    .spec_hit(spec_s), .clean_hit(clean_s)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_free
    assign free_vec[g] = (tag_q[g] == TAG_EMPTY);
  end

  txbuf_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick (
    .free_vec(free_vec), .found(found), .idx(fidx)
  );

  // speculative copy takes precedence for local reads
  assign rd_sel = (|spec_l) ? spec_l : clean_l;

  txbuf_rdmux #(.N(ENTRIES), .W(LINE_W)) u_rd_loc (
    .sel(rd_sel), .lines(data_q), .q(rd_line)
  );

  txbuf_rdmux #(.N(ENTRIES), .W(LINE_W)) u_rd_snp (
    .sel(clean_s), .lines(data_q), .q(snp_line)
  );

  txbuf_nest #(.DW(NEST_W)) u_nest (
    .clk(clk), .rst(rst),
    .begin_i(tx_begin), .end_i(tx_end), .abort_i(abort_now),
    .active_o(tx_active), .commit_o(commit_now)
  );

  // local write: entry selection and tag changes
  always_comb begin
    tag_w  = tag_q;
    wr_vec = '0;
    wr_ok  = 1'b0;
    ovf    = 1'b0;
    if (accept && req_write) begin
      if (|spec_l) begin
        wr_vec = spec_l;
        wr_ok  = 1'b1;
      end else if (!tx_active) begin
        if (|clean_l) begin
          wr_vec = clean_l;
          wr_ok  = 1'b1;
        end else if (found) begin
          wr_vec[fidx] = 1'b1;
          tag_w[fidx]  = TAG_NORMAL;
          wr_ok        = 1'b1;
        end
      end else if (found) begin
        wr_vec[fidx] = 1'b1;
        tag_w[fidx]  = TAG_XABORT;
        wr_ok        = 1'b1;
        for (int i = 0; i < ENTRIES; i++) begin
          if (clean_l[i]) tag_w[i] = TAG_XCOMMIT;
        end
      end else begin
        ovf = 1'b1;
      end
    end
  end

  assign snp_conflict = snp_valid && (|spec_s);
  assign ext_abort    = tx_abort && tx_active;
  assign abort_now    = snp_conflict || ovf || ext_abort;

  always_comb begin
    if (snp_conflict)   cause = ABT_SNOOP;
    else if (ovf)       cause = ABT_OVERFLOW;
    else if (ext_abort) cause = ABT_EXTERNAL;
    else                cause = ABT_NONE;
  end

  // bulk commit / abort transform on top of the local update
  for (genvar g = 0; g < ENTRIES; g++) begin : g_next
    always_comb begin
      if (abort_now)       tag_d[g] = tag_on_abort(tag_w[g]);
      else if (commit_now) tag_d[g] = tag_on_commit(tag_w[g]);
      else                 tag_d[g] = tag_w[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tag_q <= '0;
    else     tag_q <= tag_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[g] <= '0;
        data_q[g] <= '0;
      end else if (wr_vec[g]) begin
        addr_q[g] <= req_addr;
        data_q[g] <= req_wdata;
      end
    end
  end

  // local response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= req_write ? wr_ok : (|rd_sel);
      rsp_data  <= req_write ? '0 : rd_line;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // snoop response and abort report
  always_ff @(posedge clk) begin
    if (rst) begin
      snp_rsp_valid    <= 1'b0;
      snp_rsp_hit      <= 1'b0;
      snp_rsp_conflict <= 1'b0;
      snp_rsp_data     <= '0;
      abort_o          <= 1'b0;
      abort_cause      <= ABT_NONE;
    end else begin
      snp_rsp_valid    <= snp_valid;
      snp_rsp_hit      <= snp_valid && !snp_conflict && (|clean_s);
      snp_rsp_conflict <= snp_conflict;
      snp_rsp_data     <= (snp_valid && !snp_conflict) ? snp_line : '0;
      abort_o          <= abort_now;
      abort_cause      <= cause;
    end
  end
endmodule

// File: rtl/txbuf_ctrl_chk.sv
`timescale 1ns/1ps
module txbuf_ctrl_chk #(
  parameter int LINE_W = 256
)(
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [LINE_W-1:0] rsp_data,
  input logic              snp_rsp_valid,
  input logic              snp_rsp_hit,
  input logic              snp_rsp_conflict,
  input logic              tx_active,
  input logic              abort_o,
  input logic [1:0]        abort_cause
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!tx_active && !rsp_valid && !abort_o && !snp_rsp_valid));

  p_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_rsp_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_data)));

  p_abort_closes_r6: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> !tx_active);

  p_snoop_abort_r7: assert property (@(posedge clk) disable iff (rst)
    snp_rsp_conflict |-> (snp_rsp_valid && abort_o && abort_cause == 2'd1));

  p_no_spec_supply_r7: assert property (@(posedge clk) disable iff (rst)
    snp_rsp_conflict |-> !snp_rsp_hit);

  p_overflow_resp_r8: assert property (@(posedge clk) disable iff (rst)
    (abort_o && abort_cause == 2'd2) |-> (rsp_valid && !rsp_hit));
endmodule

bind txbuf_ctrl txbuf_ctrl_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
  .snp_rsp_valid(snp_rsp_valid), .snp_rsp_hit(snp_rsp_hit),
  .snp_rsp_conflict(snp_rsp_conflict), .tx_active(tx_active),
  .abort_o(abort_o), .abort_cause(abort_cause)
);

// File: tb/tb_txbuf_ctrl.sv
`timescale 1ns/1ps
module tb_txbuf_ctrl;
  localparam int ENTRIES = 4;
  localparam int LINE_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int NEST_W  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [ADDR_W-1:0] req_addr = '0, snp_addr = '0;
  logic [LINE_W-1:0] req_wdata = '0;
  logic snp_valid = 1'b0, tx_begin = 1'b0, tx_end = 1'b0, tx_abort = 1'b0;
  logic req_ready, rsp_valid, rsp_hit, snp_rsp_valid, snp_rsp_hit, snp_rsp_conflict;
  logic tx_active, abort_o;
  logic [1:0] abort_cause;
  logic [LINE_W-1:0] rsp_data, snp_rsp_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  txbuf_ctrl #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .ADDR_W(ADDR_W), .NEST_W(NEST_W)) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_rsp_valid(snp_rsp_valid), .snp_rsp_hit(snp_rsp_hit),
    .snp_rsp_conflict(snp_rsp_conflict), .snp_rsp_data(snp_rsp_data),
    .tx_begin(tx_begin), .tx_end(tx_end), .tx_abort(tx_abort),
    .tx_active(tx_active), .abort_o(abort_o), .abort_cause(abort_cause)
  );

  // op: 0 read, 1 write, 2 snoop
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic        exp_hit;
    logic [31:0] exp_data;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd1, 8'h10, 32'h0000_00A1, 1'b1, 32'h0},          // R2 write miss -> entry 0
    '{2'd0, 8'h10, 32'h0,         1'b1, 32'h0000_00A1},  // R2 read back
    '{2'd1, 8'h10, 32'h0000_00A2, 1'b1, 32'h0},          // R2 overwrite
    '{2'd0, 8'h10, 32'h0,         1'b1, 32'h0000_00A2},  // R2 new value
    '{2'd0, 8'h20, 32'h0,         1'b0, 32'h0},          // R11 read miss
    '{2'd2, 8'h10, 32'h0,         1'b1, 32'h0000_00A2},  // R7 clean snoop supplied
    '{2'd1, 8'h20, 32'h0000_00B1, 1'b1, 32'h0},          // R2 write miss -> entry 1
    '{2'd0, 8'h20, 32'h0,         1'b1, 32'h0000_00B1}   // R2 read back
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic local_op(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic snoop(input logic [7:0] a);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = a;
    @(posedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  // kind: 0 begin, 1 end, 2 abort request
  task automatic ctrl(input int kind);
    @(negedge clk);
    tx_begin = (kind == 0); tx_end = (kind == 1); tx_abort = (kind == 2);
    @(posedge clk);
    @(negedge clk);
    tx_begin = 1'b0; tx_end = 1'b0; tx_abort = 1'b0;
  endtask

  task automatic read_exp(input logic [7:0] a, input logic h, input logic [31:0] d, input string req);
    local_op(1'b0, a, '0);
    chk(rsp_valid && rsp_hit == h, req, {31'b0, rsp_hit}, {31'b0, h});
    chk(rsp_data == d, req, rsp_data, d);
  endtask

  task automatic write_exp(input logic [7:0] a, input logic [31:0] d, input logic h, input string req);
    local_op(1'b1, a, d);
    chk(rsp_valid && rsp_hit == h, req, {31'b0, rsp_hit}, {31'b0, h});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!tx_active, "R1 tx_active", {31'b0, tx_active}, 32'h0);
    chk(!rsp_valid && req_ready, "R1 rsp_valid/req_ready", {30'b0, rsp_valid, req_ready}, 32'h1);
    chk(!abort_o && !snp_rsp_valid, "R1 abort/snoop", {30'b0, abort_o, snp_rsp_valid}, 32'h0);
    rst = 1'b0;
    read_exp(8'h10, 1'b0, 32'h0, "R1 empty after reset");

    // table walk
    for (int i = 0; i < 8; i++) begin
      if (VEC[i].op == 2'd2) begin
        snoop(VEC[i].addr);
        chk(snp_rsp_valid && snp_rsp_hit == VEC[i].exp_hit && !snp_rsp_conflict,
            "R7 clean snoop", {31'b0, snp_rsp_hit}, {31'b0, VEC[i].exp_hit});
        chk(snp_rsp_data == VEC[i].exp_data && !abort_o, "R7 clean snoop data",
            snp_rsp_data, VEC[i].exp_data);
      end else begin
        local_op(VEC[i].op[0], VEC[i].addr, VEC[i].data);
        chk(rsp_valid && rsp_hit == VEC[i].exp_hit, "R2/R11 vector hit",
            {31'b0, rsp_hit}, {31'b0, VEC[i].exp_hit});
        chk(rsp_data == VEC[i].exp_data, "R2/R11 vector data", rsp_data, VEC[i].exp_data);
      end
    end

    // R3 back-pressure on the response
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h10;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && !req_ready, "R3 stall", {30'b0, rsp_valid, req_ready}, 32'h2);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid && rsp_data == 32'hA2, "R3 held data", rsp_data, 32'hA2);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R3 release", {30'b0, rsp_valid, req_ready}, 32'h1);

    // R10 abort request while idle is ignored
    ctrl(2);
    chk(!abort_o && !tx_active, "R10 idle abort ignored", {30'b0, abort_o, tx_active}, 32'h0);

    // R4/R6/R10 external abort restores old data
    ctrl(0);
    chk(tx_active, "R9 begin opens", {31'b0, tx_active}, 32'h1);
    write_exp(8'h10, 32'h0000_00C1, 1'b1, "R4 tx write to normal line");
    write_exp(8'h60, 32'h0000_00D1, 1'b1, "R4 tx write miss");
    read_exp(8'h10, 1'b1, 32'hC1, "R4 read speculative copy");
    read_exp(8'h60, 1'b1, 32'hD1, "R4 read new speculative line");
    ctrl(2);
    chk(abort_o && abort_cause == 2'd3, "R10 external abort cause", {30'b0, abort_cause}, 32'h3);
    chk(!tx_active, "R6 closed after abort", {31'b0, tx_active}, 32'h0);
    read_exp(8'h10, 1'b1, 32'hA2, "R6 old copy restored");
    read_exp(8'h60, 1'b0, 32'h0, "R6 speculative line dropped");

    // R7 snoop conflict
    ctrl(0);
    write_exp(8'h20, 32'h0000_00E1, 1'b1, "R4 tx write second line");
    snoop(8'h20);
    chk(snp_rsp_valid && snp_rsp_conflict && !snp_rsp_hit, "R7 conflict flags",
        {30'b0, snp_rsp_conflict, snp_rsp_hit}, 32'h2);
    chk(snp_rsp_data == 32'h0, "R7 speculative data withheld", snp_rsp_data, 32'h0);
    chk(abort_o && abort_cause == 2'd1 && !tx_active, "R7 abort cause",
        {30'b0, abort_cause}, 32'h1);
    read_exp(8'h20, 1'b1, 32'hB1, "R6 restored after snoop abort");

    // R9/R5 nested transaction, outermost end commits
    ctrl(0);
    ctrl(0);
    write_exp(8'h10, 32'h0000_00F1, 1'b1, "R4 nested tx write");
    snoop(8'h20);
    chk(snp_rsp_hit && snp_rsp_data == 32'hB1 && !abort_o, "R7 unrelated snoop supplied",
        snp_rsp_data, 32'hB1);
    ctrl(1);
    chk(tx_active, "R9 inner end keeps tx open", {31'b0, tx_active}, 32'h1);
    ctrl(1);
    chk(!tx_active && !abort_o, "R9 outer end closes", {30'b0, tx_active, abort_o}, 32'h0);
    read_exp(8'h10, 1'b1, 32'hF1, "R5 committed data");
    ctrl(1);
    chk(!tx_active && !abort_o, "R9 idle end ignored", {30'b0, tx_active, abort_o}, 32'h0);
    read_exp(8'h10, 1'b1, 32'hF1, "R9 data after idle end");
    // two entries must be free after commit: saved copy released
    write_exp(8'h30, 32'h0000_0031, 1'b1, "R5 freed entry reused");
    write_exp(8'h40, 32'h0000_0041, 1'b1, "R5 second free entry");
    write_exp(8'h50, 32'h0000_0051, 1'b0, "R2 full buffer rejects write");
    chk(!abort_o, "R2 no abort outside tx", {31'b0, abort_o}, 32'h0);

    // R8 overflow inside a transaction
    ctrl(0);
    write_exp(8'h20, 32'h0000_0077, 1'b0, "R8 overflow write rejected");
    chk(abort_o && abort_cause == 2'd2 && !tx_active, "R8 overflow abort cause",
        {30'b0, abort_cause}, 32'h2);
    read_exp(8'h20, 1'b1, 32'hB1, "R8 data unchanged after overflow");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule